// File: doc/BRIEF.md
# Scalar Arithmetic Shift-Right Execute Unit

This combinational unit decodes a 32-bit instruction word and performs a sign-filling right shift on a source operand. It recognises four scalar encodings: a shift count taken from a second register and a shift count held in the instruction, each in a 32-bit and a 64-bit data size. It presents the destination and source register indices and a 64-bit result.

The source register indices go to the register file. The two operand values that come back are fed to `rnVal` and `rmVal`, and the unit forms the result in the same cycle. A word that matches none of the four encodings drops `resValid` and forces the result to zero. The condition flags are never touched, so the unit has no flag output.

Top module: `asr_exec_unit`

## Requirements
- R1: The register-count form is recognised when instruction bits 30:21 equal `0011010110` and bits 15:10 equal `001010`, for either value of bit 31 (base words 0x9AC02800 and 0x1AC02800).
- R2: Bit 31 picks the data size: 1 selects 64-bit operation and 0 selects 32-bit operation.
- R3: In the register-count form, the shift count is `rmVal` modulo the data size: its low 6 bits for 64-bit and its low 5 bits for 32-bit.
- R4: The immediate-count form is recognised when bits 30:23 equal `00100110`, bit 22 equals bit 31, and bits 15:10 equal `111111` for 64-bit or `011111` for 32-bit (base words 0x9340FC00 and 0x13007C00).
- R5: In the immediate-count form, the shift count is bits 21:16. A 32-bit word with bit 21 set is not a match.
- R6: The vacated upper positions take copies of the sign bit: bit 63 in 64-bit operation, bit 31 in 32-bit operation.
- R7: In 32-bit operation only `rnVal[31:0]` is used, and the 32-bit result is zero-extended, so `resVal[63:32]` is 0.
- R8: A shift count of zero returns the operand unchanged, after zero extension in 32-bit operation.
- R9: Any word outside the four forms gives `resValid` low and `resVal` equal to zero.
- R10: `rdIdx` is bits 4:0, `rnIdx` is bits 9:5 and `rmIdx` is bits 20:16 of the instruction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insnWord | input | 32 | Instruction word to decode |
| rnVal | input | 64 | Value of the register to be shifted |
| rmVal | input | 64 | Value of the count register (register-count form) |
| resValid | output | 1 | High when the word is one of the four shift forms |
| rdIdx | output | 5 | Destination register index |
| rnIdx | output | 5 | Index of the register to be shifted |
| rmIdx | output | 5 | Index of the count register |
| resVal | output | 64 | Shift result, zero when resValid is low |

## Verification
The bench aims at counts of 32 and above in the 32-bit register form. A unit that skips the modulo would return all sign bits there instead of a small shift. It drives garbage into the upper half of the operand in 32-bit mode, which an unmasked design would leak into the result or use as the sign. It also sends near-miss words: N not equal to sf, a wrong imms value, a 32-bit immr with bit 5 set, and a logical-shift opcode. A decoder that is too loose would raise valid on any of these. A sweep over every count in every form with negative and positive operands catches a zero fill put where a sign fill belongs.

// File: rtl/asr_pkg.sv
`timescale 1ns/1ps
package asr_pkg;
  localparam int IMMR_W = 6;
  localparam logic [9:0] REG_OPC = 10'b0011010110;  // bits 30:21
  localparam logic [5:0] REG_SUB = 6'b001010;       // bits 15:10
  localparam logic [7:0] IMM_OPC = 8'b00100110;     // bits 30:23

  typedef struct packed {
    logic              hit;     // one of the four forms matched
    logic              wide;    // 64-bit data size
    logic              useImm;  // count comes from the instruction
    logic [IMMR_W-1:0] immAmt;  // immediate shift count
  } asr_ctrl_t;
endpackage

// File: rtl/asr_decode.sv
`timescale 1ns/1ps
module asr_decode
  import asr_pkg::*;
#(
  parameter int INSN_W = 32
) (
  input  logic [INSN_W-1:0] insnWord,
  output asr_ctrl_t         ctrl
);
  logic              sf;
  logic [5:0]        immsField;
  logic [IMMR_W-1:0] immrField;
  logic              regHit;
  logic              immHit;

  assign sf        = insnWord[31];
  assign immsField = insnWord[15:10];
  assign immrField = insnWord[21:16];

  always_comb begin
    regHit = (insnWord[30:21] == REG_OPC) && (immsField == REG_SUB);
    immHit = (insnWord[30:23] == IMM_OPC)
          && (insnWord[22] == sf)
          && (immsField == {sf, 5'b11111})
          && (sf || !immrField[IMMR_W-1]);
    ctrl.hit    = regHit || immHit;
    ctrl.wide   = sf;
    ctrl.useImm = immHit;
    ctrl.immAmt = immrField;
  end
endmodule

// File: rtl/asr_datapath.sv
`timescale 1ns/1ps
module asr_datapath
  import asr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  asr_ctrl_t        ctrl,
  input  logic [XLEN-1:0]  rnVal,
  input  logic [XLEN-1:0]  rmVal,
  output logic [XLEN-1:0]  resVal
);
  localparam int AMT_W = $clog2(XLEN);
  localparam int HALF  = XLEN / 2;

  logic [AMT_W-1:0]       amt;
  logic signed [XLEN-1:0] wideRes;
  logic signed [HALF-1:0] narrowRes;
  logic signed [HALF-1:0] narrowSrc;

  always_comb begin
    if (ctrl.useImm) amt = ctrl.immAmt[AMT_W-1:0];
    else             amt = rmVal[AMT_W-1:0];
    if (!ctrl.wide)  amt[AMT_W-1] = 1'b0;
  end

  assign narrowSrc = rnVal[HALF-1:0];
  assign wideRes   = $signed(rnVal) >>> amt;
  assign narrowRes = narrowSrc >>> amt[AMT_W-2:0];

  always_comb begin
    if (!ctrl.hit)     resVal = '0;
    else if (ctrl.wide) resVal = wideRes;
    else               resVal = {{HALF{1'b0}}, narrowRes};
  end
endmodule

// File: rtl/asr_exec_unit.sv
`timescale 1ns/1ps
module asr_exec_unit
  import asr_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int INSN_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic [INSN_W-1:0] insnWord,
  input  logic [XLEN-1:0]   rnVal,
  input  logic [XLEN-1:0]   rmVal,
  output logic              resValid,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [IDX_W-1:0]  rnIdx,
  output logic [IDX_W-1:0]  rmIdx,
  output logic [XLEN-1:0]   resVal
);
  asr_ctrl_t ctrl;

  asr_decode #(.INSN_W(INSN_W)) u_decode (
    .insnWord(insnWord),
    .ctrl    (ctrl)
  );

  asr_datapath #(.XLEN(XLEN)) u_datapath (
    .ctrl  (ctrl),
    .rnVal (rnVal),
    .rmVal (rmVal),
    .resVal(resVal)
  );

  assign resValid = ctrl.hit;
  assign rdIdx    = insnWord[IDX_W-1:0];
  assign rnIdx    = insnWord[5 +: IDX_W];
  assign rmIdx    = insnWord[16 +: IDX_W];
endmodule

// File: rtl/asr_exec_checker.sv
`timescale 1ns/1ps
module asr_exec_checker #(
  parameter int XLEN   = 64,
  parameter int INSN_W = 32
) (
  input logic [INSN_W-1:0] insnWord,
  input logic [XLEN-1:0]   rnVal,
  input logic [XLEN-1:0]   rmVal,
  input logic              resValid,
  input logic [XLEN-1:0]   resVal
);
  localparam int HALF = XLEN / 2;

  always_comb begin
    if (!resValid)
      AST_INVALID_ZERO: assert (resVal == '0);  // R9
    if (resValid && !insnWord[31])
      AST_NARROW_UPPER_CLEAR: assert (resVal[XLEN-1:HALF] == '0);  // R7
    if (resValid && insnWord[31])
      AST_WIDE_SIGN_KEPT: assert (resVal[XLEN-1] == rnVal[XLEN-1]);  // R6
    if (resValid && !insnWord[31])
      AST_NARROW_SIGN_KEPT: assert (resVal[HALF-1] == rnVal[HALF-1]);  // R6
    if (resValid && insnWord[31] && insnWord[30:21] == 10'b0011010110
        && rmVal[5:0] == 6'd0)
      AST_ZERO_COUNT_IDENTITY: assert (resVal == rnVal);  // R8
    if ((insnWord & 32'h7FE0FC00) == 32'h1AC02800)
      AST_REG_FORM_VALID: assert (resValid);  // R1
  end
endmodule

bind asr_exec_unit asr_exec_checker #(.XLEN(XLEN), .INSN_W(INSN_W)) u_chk (
  .insnWord(insnWord),
  .rnVal   (rnVal),
  .rmVal   (rmVal),
  .resValid(resValid),
  .resVal  (resVal)
);

// File: tb/asr_exec_unit_bench.sv
`timescale 1ns/1ps
module asr_exec_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insnWord;
  logic [63:0] rnVal, rmVal;
  logic        resValid;
  logic [4:0]  rdIdx, rnIdx, rmIdx;
  logic [63:0] resVal;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  asr_exec_unit u_asr_exec_unit (
    .insnWord(insnWord), .rnVal(rnVal), .rmVal(rmVal),
    .resValid(resValid), .rdIdx(rdIdx), .rnIdx(rnIdx), .rmIdx(rmIdx),
    .resVal(resVal)
  );

  function automatic logic [31:0] encReg(input bit sf, input [4:0] rm, rn, rd);
    return {sf, 10'b0011010110, rm, 6'b001010, rn, rd};
  endfunction

  function automatic logic [31:0] encImm(input bit sf, input [5:0] immr, input [4:0] rn, rd);
    return {sf, 2'b00, 6'b100110, sf, immr, (sf ? 6'b111111 : 6'b011111), rn, rd};
  endfunction

  // behavioural model built from the requirement text
  task automatic model(input [31:0] w, input [63:0] a, b,
                       output bit v, output [63:0] r);
    logic [5:0] amt;
    logic signed [31:0] s32;
    logic signed [63:0] s64;
    bit isReg, isImm64, isImm32;
    isReg   = (w & 32'h7FE0FC00) == 32'h1AC02800;
    isImm64 = (w & 32'hFFC0FC00) == 32'h9340FC00;
    isImm32 = (w & 32'hFFE0FC00) == 32'h13007C00;
    v = isReg || isImm64 || isImm32;
    amt = isReg ? (w[31] ? b[5:0] : {1'b0, b[4:0]}) : w[21:16];
    s64 = a;
    s32 = a[31:0];
    if (!v)        r = 64'd0;
    else if (w[31]) r = s64 >>> amt;
    else           r = {32'd0, 32'(s32 >>> amt)};
  endtask

  task automatic chk(input string req, input [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h (insn=%h rn=%h rm=%h)",
               req, act, exp, insnWord, rnVal, rmVal);
    end
  endtask

  task automatic apply(input string req, input [31:0] w, input [63:0] a, b);
    bit v; logic [63:0] r;
    insnWord = w; rnVal = a; rmVal = b;
    @(negedge clk);
    model(w, a, b, v, r);
    chk({req, " valid"}, {63'd0, resValid}, {63'd0, v});
    chk({req, " result"}, resVal, r);
  endtask

  task automatic t_idle;  // R9 with all-zero word
    apply("R9 idle", 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h3);
    chk("R9 idle valid low", {63'd0, resValid}, 64'd0);
  endtask

  task automatic t_reg64;  // R1 R2 R3 R6
    apply("R1 reg64 base", 32'h9AC02800, 64'h8000_0000_0000_0000, 64'd4);
    chk("R6 reg64 fill", resVal, 64'hF800_0000_0000_0000);
    apply("R6 reg64 max", encReg(1, 2, 1, 0), 64'h8123_4567_89AB_CDEF, 64'd63);
    chk("R6 reg64 all ones", resVal, 64'hFFFF_FFFF_FFFF_FFFF);
    apply("R3 reg64 mod", encReg(1, 2, 1, 0), 64'h7000_0000_0000_0000, 64'd67);
    chk("R3 reg64 67 is 3", resVal, 64'h0E00_0000_0000_0000);
    apply("R3 reg64 0xFF", encReg(1, 2, 1, 0), 64'hF000_0000_0000_0000, 64'hFF);
    apply("R8 reg64 zero", encReg(1, 3, 4, 5), 64'hDEAD_BEEF_0123_4567, 64'h40);
    chk("R8 reg64 identity", resVal, 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic t_reg32;  // R2 R3 R7
    apply("R2 reg32 base", 32'h1AC02800, 64'hFFFF_FFFF_8000_0000, 64'd4);
    chk("R7 reg32 fill/zext", resVal, 64'h0000_0000_F800_0000);
    apply("R7 reg32 garbage", encReg(0, 1, 1, 1), 64'hFFFF_0000_4000_0000, 64'd1);
    chk("R7 reg32 upper ignored", resVal, 64'h0000_0000_2000_0000);
    apply("R3 reg32 mod 33", encReg(0, 1, 1, 1), 64'h0000_0000_8000_0000, 64'd33);
    chk("R3 reg32 33 is 1", resVal, 64'h0000_0000_C000_0000);
    apply("R8 reg32 zero", encReg(0, 1, 1, 1), 64'hAAAA_AAAA_1234_5678, 64'd32);
    chk("R8 reg32 identity zext", resVal, 64'h0000_0000_1234_5678);
  endtask

  task automatic t_imm;  // R4 R5
    apply("R4 imm64 base", 32'h9340FC00, 64'h8000_0000_0000_0001, 64'd9);
    apply("R5 imm64 63", encImm(1, 6'd63, 7, 8), 64'h8000_0000_0000_0000, 64'd0);
    chk("R5 imm64 63 ones", resVal, 64'hFFFF_FFFF_FFFF_FFFF);
    apply("R4 imm32 base", 32'h13007C00, 64'hFFFF_FFFF_1234_5678, 64'd9);
    apply("R5 imm32 31", encImm(0, 6'd31, 7, 8), 64'h0000_0000_8000_0000, 64'd0);
    chk("R5 imm32 31 ones", resVal, 64'h0000_0000_FFFF_FFFF);
    apply("R5 imm32 immr32", encImm(0, 6'd32, 7, 8), 64'h8000_0000_8000_0000, 64'd0);
    chk("R5 imm32 bit5 invalid", {63'd0, resValid}, 64'd0);
  endtask

  task automatic t_reject;  // R4 R9
    apply("R4 bad N", encImm(1, 6'd3, 1, 2) & ~32'h0040_0000, 64'h8000_0000_0000_0000, 0);
    chk("R4 bad N invalid", {63'd0, resValid}, 64'd0);
    apply("R4 bad imms", encImm(0, 6'd3, 1, 2) | 32'h0000_8000, 64'h8000_0000, 0);
    chk("R4 bad imms invalid", {63'd0, resValid}, 64'd0);
    apply("R9 lsr word", 32'h9AC02400, 64'h8000_0000_0000_0000, 64'd2);
    chk("R9 other opcode zero", resVal, 64'd0);
  endtask

  task automatic t_fields;  // R10
    apply("R10 fields", encReg(1, 5'd17, 5'd9, 5'd30), 64'd5, 64'd1);
    chk("R10 rd", {59'd0, rdIdx}, 64'd30);
    chk("R10 rn", {59'd0, rnIdx}, 64'd9);
    chk("R10 rm", {59'd0, rmIdx}, 64'd17);
  endtask

  task automatic t_sweep;  // R3 R5 R6 every count
    for (int s = 0; s < 64; s++) begin
      apply("R6 sweep reg64", encReg(1, 2, 3, 4), 64'hC3A5_0F0F_1234_8765, 64'(s));
      apply("R6 sweep reg32", encReg(0, 2, 3, 4), 64'h1111_2222_9ABC_DEF0, 64'(s));
      apply("R5 sweep imm64", encImm(1, 6'(s), 3, 4), 64'h4A5A_0F0F_1234_8765, 64'd0);
      if (s < 32)
        apply("R5 sweep imm32", encImm(0, 6'(s), 3, 4), 64'h0000_0000_8765_4321, 64'd0);
    end
  endtask

  initial begin
    insnWord = '0; rnVal = '0; rmVal = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_idle();
    t_reg64();
    t_reg32();
    t_imm();
    t_reject();
    t_fields();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule